// File: doc/BRIEF.md
# Two-Stage Serial Clock Generator

This block derives the serial bit clock for a serial peripheral (SPI) shift engine from the controller clock. It divides in two cascaded stages. The first stage is an even-only prescaler. The second stage is a post-divider that divides by its programmed value plus one. The total ratio from the controller clock to the serial clock is `(post + 1) * pre`. That ratio is always even, so each serial clock phase lasts exactly `(post + 1) * pre / 2` controller cycles and the duty cycle is an exact 50%.

Beside the serial clock, the block produces two single-cycle strobes. One marks the cycle in which the serial clock leaves its idle level. The other marks the cycle in which it returns to that level. The shift engine uses these strobes to launch and capture data without watching the clock itself.

The divider fields and the idle polarity are captured only while the generator is disabled. Writes made while it runs take effect at the start of the next frame. Computing the field values from a requested bit rate is left to the caller.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted, `sclk`, `lead_pulse` and `trail_pulse` are all low.
- R2: While `en` is low, the block is idle. Both strobes stay low, and `sclk` equals the `cpol` value sampled at the previous clock edge. The internal counters restart from zero.
- R3: Let H = `(post_div + 1) * (pre_div >> 1)`. Count rising clock edges from the first edge that samples `en` high as edge 1. Then `sclk` changes level after edge k*H, for every k >= 1, and at no other edge while enabled.
- R4: `lead_pulse` is high for exactly the one cycle in which `sclk` has just left the idle level (after edges H, 3H, 5H, ...), and is low otherwise.
- R5: `trail_pulse` is high for exactly the one cycle in which `sclk` has just returned to the idle level (after edges 2H, 4H, ...), and is low otherwise. The two strobes are never high together.
- R6: While enabled, the high and low phases of `sclk` each last exactly H cycles, which gives a 50% duty cycle.
- R7: The least significant bit of `pre_div` is ignored. A `pre_div` of 0 or 1 acts as 2.
- R8: Changes to `pre_div`, `post_div` or `cpol` while `en` is high do not alter the running waveform. The new values are used from the next time `en` rises.
- R9: The smallest setting (`pre_div` = 2, `post_div` = 0) toggles `sclk` after every edge, for a ratio of 2. The largest setting (`pre_div` = 254, `post_div` = 255) gives H = 32512, for a ratio of 65024.
- R10: Dropping `en` in the middle of a frame returns `sclk` to the idle level after the next edge without a strobe, even when that edge would have toggled the clock. The next enable restarts the timing of R3 from edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Run the generator; low holds it idle |
| cpol | input | 1 | Idle level of the serial clock |
| pre_div | input | DIV_W | Prescaler field; the LSB is ignored, and 0 or 1 acts as 2 |
| post_div | input | DIV_W | Post-divider field; divides by the value plus one |
| sclk | output | 1 | Serial bit clock |
| lead_pulse | output | 1 | One-cycle strobe when sclk leaves the idle level |
| trail_pulse | output | 1 | One-cycle strobe when sclk returns to the idle level |

## Verification
Two events can fall on the same cycle. One is the disable path. The other is the post-divider terminal count, which would toggle the clock. The bench provokes this by lowering `en` so that the first edge sampling it low is exactly edge H, where a leading transition is due. It judges the result by requiring `sclk` at the idle level with neither strobe high, and then a clean restart from edge 1. A second collision is a field write landing while the counters run. For that, random new fields and an inverted polarity are driven mid-frame, and the waveform must still match the one predicted from the values captured at enable.

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cpol,
  input  logic [DIV_W-1:0] pre_div,
  input  logic [DIV_W-1:0] post_div,
  output logic             sclk,
  output logic             lead_pulse,
  output logic             trail_pulse
);
  localparam int PC_W = DIV_W - 1;
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic [DIV_W-1:0] pre_q, post_q;
  logic             cpol_q;
  logic [PC_W-1:0]  pc;
  logic [DIV_W-1:0] qc;
  logic             ph, lead_q, trail_q;

  wire [PC_W-1:0] half_pre = (pre_q[DIV_W-1:1] == '0) ? PC_ONE : pre_q[DIV_W-1:1];
  wire            pre_tick = (pc == half_pre - PC_ONE);
  wire            flip     = pre_tick && (qc == post_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      post_q <= '0;
      cpol_q <= 1'b0;
    end else if (!en) begin
      pre_q  <= pre_div;
      post_q <= post_div;
      cpol_q <= cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      qc <= '0;
    end else if (!en) begin
      pc <= '0;
      qc <= '0;
    end else begin
      pc <= pre_tick ? '0 : pc + PC_ONE;
      if (pre_tick)
        qc <= flip ? '0 : qc + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!en) begin
      ph      <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      ph      <= ph ^ flip;
      lead_q  <= flip & ~ph;
      trail_q <= flip & ph;
    end
  end

  assign sclk        = ph ^ cpol_q;
  assign lead_pulse  = lead_q;
  assign trail_pulse = trail_q;
endmodule

module spi_sclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic sclk,
  input logic lead_pulse,
  input logic trail_pulse
);
  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == $past(cpol)) && !lead_pulse && !trail_pulse);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_pulse && trail_pulse));

  // R4
  lead_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_pulse |-> (sclk != $past(sclk)) && $past(en));

  // R5
  trail_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_pulse |-> (sclk != $past(sclk)) && $past(en));

  // R3
  toggle_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (sclk != $past(sclk))) |-> (lead_pulse || trail_pulse));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
  .sclk(sclk), .lead_pulse(lead_pulse), .trail_pulse(trail_pulse)
);

// File: tb/spi_sclk_gen_tb_top.sv
module spi_sclk_gen_tb_top;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cpol = 1'b0;
  logic [7:0] pre_div = 8'd2;
  logic [7:0] post_div = 8'd0;
  wire        sclk, lead_pulse, trail_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_sclk_gen #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
    .pre_div(pre_div), .post_div(post_div),
    .sclk(sclk), .lead_pulse(lead_pulse), .trail_pulse(trail_pulse)
  );

  function automatic int half_of(logic [7:0] p, logic [7:0] q);
    int hp = int'(p[7:1]);
    if (hp == 0) hp = 1;
    return (int'(q) + 1) * hp;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, expv);
    end
  endtask

  task automatic run(logic [7:0] p, logic [7:0] q, bit cp, int ncyc,
                     bit perturb, string tag, string idle_tag);
    int h = half_of(p, q);
    bit bad = 1'b0;
    int bad_n = 0;
    int act = 0;
    int expv = 0;
    @(negedge clk);
    pre_div = p; post_div = q; cpol = cp;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    for (int n = 1; n <= ncyc; n++) begin
      int  k;
      bit  tog;
      logic es, el, et;
      @(negedge clk);
      k   = n / h;
      tog = (n % h) == 0;
      es  = cp ^ k[0];
      el  = tog && k[0];
      et  = tog && !k[0];
      if (!bad && ({sclk, lead_pulse, trail_pulse} !== {es, el, et})) begin
        bad   = 1'b1;
        bad_n = n;
        act   = int'({sclk, lead_pulse, trail_pulse});
        expv  = int'({es, el, et});
      end
      if (perturb && n == 2) begin
        pre_div  = 8'($urandom);
        post_div = 8'($urandom);
        cpol     = ~cp;
      end
    end
    check(!bad, tag, $sformatf("pre=%0d post=%0d {sclk,lead,trail} at cycle %0d",
          p, q, bad_n), act, expv);
    en = 1'b0;
    @(negedge clk);
    check({sclk, lead_pulse, trail_pulse} === {cpol, 2'b00}, idle_tag,
          "idle {sclk,lead,trail} after disable",
          int'({sclk, lead_pulse, trail_pulse}), int'({cpol, 2'b00}));
  endtask

  initial begin
    #(CLK_NS * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: outputs low in reset
    @(negedge clk);
    @(negedge clk);
    check({sclk, lead_pulse, trail_pulse} === 3'b000, "R1", "reset outputs",
          int'({sclk, lead_pulse, trail_pulse}), 0);
    rst_n = 1'b1;

    // R2: idle level follows cpol
    cpol = 1'b1;
    @(negedge clk);
    check({sclk, lead_pulse, trail_pulse} === 3'b100, "R2", "idle cpol=1",
          int'({sclk, lead_pulse, trail_pulse}), 4);
    cpol = 1'b0;
    @(negedge clk);
    check({sclk, lead_pulse, trail_pulse} === 3'b000, "R2", "idle cpol=0",
          int'({sclk, lead_pulse, trail_pulse}), 0);

    // R9: minimum ratio
    run(8'd2, 8'd0, 1'b0, 12, 1'b0, "R9 R3 min", "R2");
    run(8'd2, 8'd0, 1'b1, 9, 1'b0, "R9 R4 R5 min cpol=1", "R2");
    // R3 R4 R5 R6: directed settings
    run(8'd6, 8'd2, 1'b0, 40, 1'b0, "R3 R4 R5", "R2");
    run(8'd4, 8'd9, 1'b1, 90, 1'b0, "R3 R6 cpol=1", "R2");
    run(8'd10, 8'd4, 1'b1, 100, 1'b0, "R6 R4 R5", "R2");
    run(8'd254, 8'd0, 1'b0, 400, 1'b0, "R3 large pre", "R2");
    run(8'd2, 8'd255, 1'b0, 800, 1'b0, "R3 large post", "R2");
    // R7: odd and tiny prescaler values
    run(8'd7, 8'd1, 1'b0, 30, 1'b0, "R7 pre=7", "R2");
    run(8'd1, 8'd3, 1'b1, 20, 1'b0, "R7 pre=1", "R2");
    run(8'd0, 8'd0, 1'b0, 8, 1'b0, "R7 pre=0", "R2");
    // R8: mid-frame field writes ignored
    run(8'd8, 8'd3, 1'b0, 80, 1'b1, "R8", "R8");
    run(8'd3, 8'd5, 1'b1, 50, 1'b1, "R8 odd", "R8");
    // R10: disable on the edge where a toggle is due, then restart
    run(8'd12, 8'd1, 1'b1, half_of(8'd12, 8'd1) - 1, 1'b0, "R10 partial", "R10");
    run(8'd12, 8'd1, 1'b1, 30, 1'b0, "R10 restart", "R2");
    run(8'd2, 8'd0, 1'b0, 5, 1'b0, "R10 partial min", "R10");
    // random settings
    for (int i = 0; i < 15; i++) begin
      logic [7:0] p = 8'($urandom % 64);
      logic [7:0] q = 8'($urandom % 8);
      bit         cp = 1'($urandom);
      int         h = half_of(p, q);
      run(p, q, cp, 3 * h + int'($urandom % 32'(h)), 1'($urandom), "R3 R6 random", "R2");
    end
    // R9: maximum ratio, one full period
    run(8'd254, 8'd255, 1'b0, 2 * 32512 + 2, 1'b0, "R9 max", "R2");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule